// File: doc/BRIEF.md
# Virtually indexed, physically tagged L1 lookup

This block is the lookup path of a direct-mapped level-one cache that starts reading its arrays before the address translator has finished. A request carries only the untranslated page-offset part of the virtual address. Bits [13:6] of that offset choose one of 256 lines, and the tag and data arrays are read in the first cycle. In the second cycle the translator supplies a physical page number and a hit flag. The stored 26-bit tag is compared with that page number, and the cache either answers with a 64-bit word or requests the line from the next level. Because the set index never depends on translated bits, one physical page can only ever land in one place, so two virtual pages that map to the same physical page share a single cached copy.

When the tag does not match, the block raises a one-cycle request that carries the 40-bit physical address. It then stops accepting requests until a whole 64-byte line arrives on the fill port. The fill installs the tag, data and valid bit, and the held access is replayed and answered as a hit. When translation fails, the lookup is answered at once as a non-hit. No next-level request is made and nothing stalls.

Top module: `vipt_l1_lookup`

## Requirements
- R1: After reset no line is valid, `req_ready` is 1 and `resp_valid` and `l2_req` are 0, so the first lookup of any set with a translation hit is a miss.
- R2: The set is chosen only by request offset bits [13:6]. Accesses whose bits [13:6] differ use different lines. A fill for a different page number at the same index replaces the earlier line, so the earlier page then misses.
- R3: A request accepted at a clock edge is answered in the following cycle. With `xlat_hit`=1, a valid line and a stored tag equal to `xlat_ppn`, that cycle shows `resp_valid`=1 and `resp_hit`=1. Back-to-back requests are answered one per cycle.
- R4: On a hit, `resp_data` is the 64-bit word at bits [64*k+63 : 64*k] of the stored line, where k is request offset bits [5:3] (line byte 0 is in bits [7:0]).
- R5: If `xlat_hit` is 0 in the answer cycle, the block shows `resp_valid`=1 and `resp_hit`=0 whatever the stored tag is. It raises no `l2_req`, and `req_ready` stays 1.
- R6: If `xlat_hit` is 1 and the line is invalid or its tag differs, the block raises `l2_req` for exactly one cycle. `l2_pa` is then {`xlat_ppn`, 14-bit request offset}, and no response is given. `req_ready` is 0 from that cycle until the replay completes.
- R7: While a miss is outstanding, a cycle with `fill_valid`=1 writes `fill_line` and the held page number into the held set. Two cycles later the block shows `resp_valid`=1 and `resp_hit`=1 with the word from the filled line. The translator inputs are ignored during that replay.
- R8: `fill_valid` has no effect when no miss is outstanding: a later lookup of that set still misses.
- R9: `req_valid` is ignored while `req_ready` is 0: no response or request ever results from it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Lookup request |
| req_off | input | 14 | Untranslated page-offset bits of the virtual address |
| req_ready | output | 1 | Request accepted at this edge when high |
| xlat_hit | input | 1 | Translator hit, valid in the cycle after the request |
| xlat_ppn | input | 26 | Physical page number from the translator |
| resp_valid | output | 1 | Lookup answered this cycle |
| resp_hit | output | 1 | Answer is a hit |
| resp_data | output | 64 | Selected word on a hit |
| l2_req | output | 1 | Miss request to the next level (one cycle) |
| l2_pa | output | 40 | Physical address of the missing access |
| fill_valid | input | 1 | Line fill present |
| fill_line | input | 512 | Whole 64-byte line for the fill |

## Verification
A corrupted valid bit or tag shows up in the very next answer cycle: a hit turns into an `l2_req` pulse, or a miss is answered as a hit. A wrong index or word select only shows when the line is hit later, as a wrong `resp_data` word. A control state that sticks in the waiting or replay phase keeps `req_ready` low one cycle too long, or leaves out the replay answer two cycles after the fill. A reference model checked every cycle notices any of these at its first visible cycle.

// File: rtl/vipt_pkg.sv
package vipt_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_WAIT   = 2'd1,
    ST_REPLAY = 2'd2
  } lookup_state_e;
endpackage

// File: rtl/vipt_tag_store.sv
module vipt_tag_store #(
  parameter int IDX_W = 8,
  parameter int TAG_W = 26
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rd_en,
  input  logic [IDX_W-1:0] rd_idx,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [TAG_W-1:0] wr_tag,
  output logic             rd_valid,
  output logic [TAG_W-1:0] rd_tag
);
  localparam int SETS = 1 << IDX_W;

  logic [SETS-1:0]  valid_q;
  logic [TAG_W-1:0] tag_mem [SETS];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q  <= '0;
      rd_valid <= 1'b0;
    end else begin
      if (wr_en) valid_q[wr_idx] <= 1'b1;
      if (rd_en) rd_valid <= valid_q[rd_idx];
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) tag_mem[wr_idx] <= wr_tag;
    if (rd_en) rd_tag <= tag_mem[rd_idx];
  end
endmodule

// File: rtl/vipt_data_store.sv
module vipt_data_store #(
  parameter int IDX_W  = 8,
  parameter int LINE_W = 512
) (
  input  logic              clk,
  input  logic              rd_en,
  input  logic [IDX_W-1:0]  rd_idx,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [LINE_W-1:0] wr_line,
  output logic [LINE_W-1:0] rd_line
);
  localparam int SETS = 1 << IDX_W;

  logic [LINE_W-1:0] line_mem [SETS];

  always_ff @(posedge clk) begin
    if (wr_en) line_mem[wr_idx] <= wr_line;
    if (rd_en) rd_line <= line_mem[rd_idx];
  end
endmodule

// File: rtl/vipt_l1_lookup.sv
module vipt_l1_lookup
  import vipt_pkg::*;
#(
  parameter int PA_W       = 40,
  parameter int PG_OFF_W   = 14,
  parameter int LINE_OFF_W = 6,
  parameter int WORD_W     = 64
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         req_valid,
  input  logic [PG_OFF_W-1:0]          req_off,
  output logic                         req_ready,
  input  logic                         xlat_hit,
  input  logic [PA_W-PG_OFF_W-1:0]     xlat_ppn,
  output logic                         resp_valid,
  output logic                         resp_hit,
  output logic [WORD_W-1:0]            resp_data,
  output logic                         l2_req,
  output logic [PA_W-1:0]              l2_pa,
  input  logic                         fill_valid,
  input  logic [(8<<LINE_OFF_W)-1:0]   fill_line
);
  localparam int IDX_W  = PG_OFF_W - LINE_OFF_W;
  localparam int TAG_W  = PA_W - PG_OFF_W;
  localparam int LINE_W = 8 << LINE_OFF_W;
  localparam int WSEL_W = LINE_OFF_W - $clog2(WORD_W / 8);

  function automatic logic [IDX_W-1:0] set_of(input logic [PG_OFF_W-1:0] off);
    return off[PG_OFF_W-1:LINE_OFF_W];
  endfunction

  function automatic logic [WORD_W-1:0] word_of(input logic [LINE_W-1:0] line,
                                                input logic [PG_OFF_W-1:0] off);
    logic [WSEL_W-1:0] k;
    k = off[LINE_OFF_W-1:LINE_OFF_W-WSEL_W];
    return line[k*WORD_W +: WORD_W];
  endfunction

  function automatic logic [PA_W-1:0] phys_addr(input logic [TAG_W-1:0] ppn,
                                                input logic [PG_OFF_W-1:0] off);
    return {ppn, off};
  endfunction

  lookup_state_e state_q;
  logic [PG_OFF_W-1:0] hold_off;
  logic [TAG_W-1:0]    hold_ppn;

  logic                s2_valid;
  logic                s2_replay;
  logic [PG_OFF_W-1:0] s2_off;

  logic                in_wait;
  logic                in_replay;
  logic                issue;
  logic [PG_OFF_W-1:0] issue_off;
  logic                fill_we;

  logic                rd_valid;
  logic [TAG_W-1:0]    rd_tag;
  logic [LINE_W-1:0]   rd_line;

  logic [TAG_W-1:0]    ppn_eff;
  logic                xh_eff;
  logic                tag_match;
  logic                s2_hit;
  logic                s2_fault;
  logic                s2_miss;

  assign in_wait   = (state_q == ST_WAIT);
  assign in_replay = (state_q == ST_REPLAY);

  // Second stage: compare stored tag with the translated page number
  assign ppn_eff   = s2_replay ? hold_ppn : xlat_ppn;
  assign xh_eff    = s2_replay | xlat_hit;
  assign tag_match = rd_valid && (rd_tag == ppn_eff);
  assign s2_hit    = s2_valid && xh_eff && tag_match;
  assign s2_fault  = s2_valid && !xh_eff;
  assign s2_miss   = s2_valid && xh_eff && !tag_match;

  assign resp_valid = s2_hit || s2_fault;
  assign resp_hit   = s2_hit;
  assign resp_data  = word_of(rd_line, s2_off);
  assign l2_req     = s2_miss;
  assign l2_pa      = phys_addr(ppn_eff, s2_off);

  // First stage: index the arrays with untranslated bits
  assign req_ready = (state_q == ST_IDLE) && !s2_miss;
  assign issue     = in_replay || (req_valid && req_ready);
  assign issue_off = in_replay ? hold_off : req_off;
  assign fill_we   = in_wait && fill_valid;

  vipt_tag_store #(.IDX_W(IDX_W), .TAG_W(TAG_W)) u_tags (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd_en    (issue),
    .rd_idx   (set_of(issue_off)),
    .wr_en    (fill_we),
    .wr_idx   (set_of(hold_off)),
    .wr_tag   (hold_ppn),
    .rd_valid (rd_valid),
    .rd_tag   (rd_tag)
  );

  vipt_data_store #(.IDX_W(IDX_W), .LINE_W(LINE_W)) u_data (
    .clk     (clk),
    .rd_en   (issue),
    .rd_idx  (set_of(issue_off)),
    .wr_en   (fill_we),
    .wr_idx  (set_of(hold_off)),
    .wr_line (fill_line),
    .rd_line (rd_line)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s2_valid  <= 1'b0;
      s2_replay <= 1'b0;
      s2_off    <= '0;
    end else begin
      s2_valid  <= issue;
      s2_replay <= in_replay;
      if (issue) s2_off <= issue_off;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      hold_off <= '0;
      hold_ppn <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (s2_miss) begin
          state_q  <= ST_WAIT;
          hold_off <= s2_off;
          hold_ppn <= ppn_eff;
        end
        ST_WAIT:   if (fill_valid) state_q <= ST_REPLAY;
        ST_REPLAY: state_q <= ST_IDLE;
        default:   state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/vipt_l1_lookup_chk.sv
module vipt_l1_lookup_chk (
  input logic clk,
  input logic rst_n,
  input logic req_ready,
  input logic resp_valid,
  input logic resp_hit,
  input logic l2_req,
  input logic xlat_hit,
  input logic fill_valid,
  input logic s2_valid,
  input logic s2_replay,
  input logic in_wait,
  input logic in_replay
);
  p_answer_or_miss_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !(resp_valid && l2_req));

  p_fault_no_hit_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (s2_valid && !s2_replay && !xlat_hit) |-> (resp_valid && !resp_hit && !l2_req));

  p_miss_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    l2_req |=> !l2_req);

  p_miss_stalls_r6: assert property (@(posedge clk) disable iff (!rst_n)
    l2_req |-> !req_ready);

  p_miss_waits_r6: assert property (@(posedge clk) disable iff (!rst_n)
    l2_req |=> in_wait);

  p_wait_blocks_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (in_wait || in_replay) |-> !req_ready);

  p_fill_replays_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_wait && fill_valid) |=> in_replay ##1 (resp_valid && resp_hit));

  p_replay_hits_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (s2_valid && s2_replay) |-> (resp_valid && resp_hit));
endmodule

bind vipt_l1_lookup vipt_l1_lookup_chk u_chk (.*);

// File: tb/sim_vipt_l1_lookup.sv
module sim_vipt_l1_lookup;
  localparam int TW = 26;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic          req_valid = 1'b0;
  logic [13:0]   req_off = '0;
  logic          xlat_hit = 1'b0;
  logic [TW-1:0] xlat_ppn = '0;
  logic          fill_valid = 1'b0;
  logic [511:0]  fill_line = '0;
  logic          req_ready, resp_valid, resp_hit, l2_req;
  logic [63:0]   resp_data;
  logic [39:0]   l2_pa;

  vipt_l1_lookup u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_off(req_off),
    .req_ready(req_ready), .xlat_hit(xlat_hit), .xlat_ppn(xlat_ppn),
    .resp_valid(resp_valid), .resp_hit(resp_hit), .resp_data(resp_data),
    .l2_req(l2_req), .l2_pa(l2_pa), .fill_valid(fill_valid), .fill_line(fill_line)
  );

  int    checks = 0;
  int    fails = 0;
  string cur_req = "R1";
  bit    finished = 1'b0;

  // reference model state
  bit            ref_valid [256];
  logic [TW-1:0] ref_tag [256];
  logic [511:0]  ref_line [256];
  bit            m_wait, m_rep, m_s2v, m_s2rep;
  logic [13:0]   m_s2off, m_hoff;
  logic [TW-1:0] m_hppn;

  task automatic calc(output bit ev, output bit eh, output bit el2, output bit erdy,
                      output logic [39:0] epa, output logic [63:0] edata);
    logic [TW-1:0] pe;
    bit xh, hc;
    int idx, wsel;
    pe   = m_s2rep ? m_hppn : xlat_ppn;
    xh   = m_s2rep || xlat_hit;
    idx  = int'(m_s2off) / 64;
    wsel = (int'(m_s2off) / 8) % 8;
    hc   = m_s2v && xh && ref_valid[idx] && (ref_tag[idx] == pe);
    ev   = m_s2v && (hc || !xh);
    eh   = hc;
    el2  = m_s2v && xh && !hc;
    erdy = !m_wait && !m_rep && !el2;
    epa  = {pe, m_s2off};
    edata = ref_line[idx][wsel*64 +: 64];
  endtask

  always @(posedge clk) begin
    bit ev, eh, el2, erdy;
    logic [39:0] epa;
    logic [63:0] edata;
    if (!rst_n) begin
      foreach (ref_valid[i]) ref_valid[i] = 1'b0;
      m_wait = 0; m_rep = 0; m_s2v = 0; m_s2rep = 0; m_s2off = '0;
      m_hoff = '0; m_hppn = '0;
    end else begin
      calc(ev, eh, el2, erdy, epa, edata);
      if (m_wait && fill_valid) begin
        ref_valid[int'(m_hoff) / 64] = 1'b1;
        ref_tag[int'(m_hoff) / 64]   = m_hppn;
        ref_line[int'(m_hoff) / 64]  = fill_line;
        m_wait = 0; m_rep = 1; m_s2v = 0;
      end else if (m_rep) begin
        m_rep = 0; m_s2v = 1; m_s2rep = 1; m_s2off = m_hoff;
      end else if (el2) begin
        m_wait = 1; m_hoff = m_s2off; m_hppn = epa[39:14]; m_s2v = 0;
      end else if (!m_wait && req_valid) begin
        m_s2v = 1; m_s2rep = 0; m_s2off = req_off;
      end else begin
        m_s2v = 0;
      end
    end
  end

  task automatic check(input bit ok, input string what, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual=%h expected=%h", cur_req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    bit ev, eh, el2, erdy;
    logic [39:0] epa;
    logic [63:0] edata;
    if (!finished) begin
      calc(ev, eh, el2, erdy, epa, edata);
      check(req_ready === erdy, "req_ready", 64'(req_ready), 64'(erdy));
      check(resp_valid === ev, "resp_valid", 64'(resp_valid), 64'(ev));
      check(l2_req === el2, "l2_req", 64'(l2_req), 64'(el2));
      if (ev) check(resp_hit === eh, "resp_hit", 64'(resp_hit), 64'(eh));
      if (eh) check(resp_data === edata, "resp_data", resp_data, edata);
      if (el2) check(l2_pa === epa, "l2_pa", 64'(l2_pa), 64'(epa));
    end
  end

  function automatic logic [511:0] pat(input int s);
    logic [511:0] p;
    for (int i = 0; i < 8; i++) p[i*64 +: 64] = {32'(s), 32'(i * 7 + 1)};
    return p;
  endfunction

  task automatic step(input bit rv, input logic [13:0] off, input bit xh,
                      input logic [TW-1:0] ppn, input bit fv, input logic [511:0] fl);
    req_valid = rv; req_off = off; xlat_hit = xh; xlat_ppn = ppn;
    fill_valid = fv; fill_line = fl;
    @(posedge clk);
    #1;
  endtask

  task automatic idle();
    step(0, '0, 0, '0, 0, '0);
  endtask

  task automatic finish_run();
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog (all requirements): actual=hung expected=done");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    cur_req = "R1";
    idle();
    // cold miss on set 1
    step(1, 14'h0040, 0, '0, 0, '0);
    cur_req = "R6";
    step(0, '0, 1, 26'h0ABCD, 0, '0);
    cur_req = "R9";
    step(1, 14'h0100, 1, 26'h0000F, 0, '0);
    step(1, 14'h0180, 0, '0, 0, '0);
    cur_req = "R7";
    step(0, '0, 0, '0, 1, pat(1));
    step(1, 14'h0200, 1, 26'h3, 0, '0);
    step(0, '0, 0, '0, 0, '0);
    idle();
    // pipelined hits, several words
    cur_req = "R3";
    step(1, 14'h0048, 0, '0, 0, '0);
    cur_req = "R4";
    step(1, 14'h0058, 1, 26'h0ABCD, 0, '0);
    step(1, 14'h0078, 1, 26'h0ABCD, 0, '0);
    step(1, 14'h0047, 1, 26'h0ABCD, 0, '0);
    step(0, '0, 1, 26'h0ABCD, 0, '0);
    // translation failure on a present line
    cur_req = "R5";
    step(1, 14'h0040, 0, '0, 0, '0);
    step(1, 14'h0068, 0, 26'h0ABCD, 0, '0);
    step(0, '0, 1, 26'h0ABCD, 0, '0);
    // same set, other page: eviction
    cur_req = "R2";
    step(1, 14'h0047, 0, '0, 0, '0);
    step(0, '0, 1, 26'h01234, 0, '0);
    idle();
    step(0, '0, 0, '0, 1, pat(2));
    idle();
    idle();
    step(1, 14'h0040, 0, '0, 0, '0);
    step(0, '0, 1, 26'h0ABCD, 0, '0);
    step(0, '0, 0, '0, 1, pat(4));
    idle();
    idle();
    step(1, 14'h0080, 0, '0, 0, '0);
    step(0, '0, 1, 26'h0ABCD, 0, '0);
    step(0, '0, 0, '0, 1, pat(5));
    idle();
    idle();
    step(1, 14'h0088, 0, '0, 0, '0);
    step(1, 14'h0048, 1, 26'h0ABCD, 0, '0);
    step(0, '0, 1, 26'h0ABCD, 0, '0);
    // stray fill while idle
    cur_req = "R8";
    step(0, '0, 0, '0, 1, pat(9));
    step(1, 14'h00C0, 0, '0, 1, pat(9));
    step(0, '0, 1, 26'h00005, 0, '0);
    idle();
    step(0, '0, 0, '0, 1, pat(3));
    idle();
    step(0, '0, 0, 26'h00007, 0, '0);
    step(1, 14'h00F8, 0, '0, 0, '0);
    step(0, '0, 1, 26'h00005, 0, '0);
    idle();
    idle();
    finish_run();
  end
endmodule